// File: doc/BRIEF.md
# Descriptor-Chained Page Table Refill Engine

This block fills a two-dimensional page lookup table from a chain of descriptors that software builds in memory. Each descriptor names a rectangle of table slots, a table identifier and the address of an array of 32-bit page addresses, plus a pointer to the next descriptor. Software starts the engine by writing the address of the first descriptor into the pointer register. The engine fetches that descriptor, reads one page address per slot and writes each into the table at its slot. It then moves on to the next descriptor, and stops when the next pointer is zero.

A small register port gives software the pointer register, a status word, a write-one-to-clear event register with an enable mask and one interrupt line, and two constant identification words. Writing zero to the pointer register abandons the chain. Malformed descriptors and misaligned pointers stop the chain with an error.

Top module: `lut_refill_engine`

## Requirements
- R1: After reset the status word reads 0x1 (bit0 ready set, bit1 error clear), the event register reads 0, `irq` is low, and neither `mem_req_valid` nor `lut_we` is asserted.
- R2: Register 4 reads 0x01010000: one engine in bits [28:24] and NUM_LUT tables in bits [20:16]. Register 5 reads the table width divided by 32 in bits [19:16] and the height divided by 32 in bits [27:24]. With the defaults this is 0x04080000.
- R3: For each valid descriptor the engine makes exactly (x1-x0+1)*(y1-y0+1) table writes. Slot k in row-major order (x rises from x0 to x1 within a row, rows run from y0 to y1) receives the word at data pointer + 4*k. `lut_id` carries bits [7:4] of the control word.
- R4: A descriptor is four words at a 16-byte aligned address: +0 next pointer, +4 corners (x0 bits [7:0], y0 [15:8], x1 [23:16], y1 [31:24]), +8 control (bit0 start, bits [7:4] table id), +12 data pointer. The engine follows non-zero next pointers and ends the chain at a zero next pointer.
- R5: The ready bit (status bit0) is low while a chain is being walked. A non-zero pointer write that arrives while ready is low has no effect.
- R6: Event register (index 2) bit1 is set when the last descriptor of a chain finishes. Any event bit is cleared by writing 1 to it, and a set and a clear in the same cycle leave the bit set.
- R7: A misaligned start pointer, next pointer or data pointer (low four bits non-zero) sets the error bit (status bit1) and event bit2, and stops the chain. The slots of earlier descriptors keep their writes. A misaligned start pointer issues no memory read.
- R8: A descriptor with x1<x0, y1<y0, x1 or y1 beyond the table size, or a clear start bit causes no table write, sets the error bit and event bit2, and ends the chain. A later accepted start clears the error bit.
- R9: Writing zero to the pointer register stops the walk. No table write happens after that. A memory response still in flight is discarded, and ready returns once that response has come back.
- R10: Event bit0 is set each time a descriptor is fully fetched. `irq` is the OR of event bits ANDed with the enable register (index 3), so an enable of 0x7E masks the bit0 source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked event interrupt |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| lut_we | output | 1 | Table write strobe |
| lut_id | output | 4 | Target table id |
| lut_x | output | 8 | Slot column |
| lut_y | output | 8 | Slot row |
| lut_data | output | 32 | Page address written to the slot |

## Verification
The hardest case to reach is a cancel that lands while a read response is still in flight. If that response is not absorbed, it would be taken as the first word of the next chain. The bench gives its memory model a two-cycle latency and a randomly stalling ready. It cancels a 32-slot rectangle partway through, when the engine is almost always waiting on a response. It then checks that no write follows and that a fresh chain afterwards matches its expected values exactly. Randomly built chains with injected faults on the final descriptor cover the error paths in the middle of a walk.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef struct packed {
    logic [7:0] y1;
    logic [7:0] x1;
    logic [7:0] y0;
    logic [7:0] x0;
  } rect_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DWAIT, S_CHECK, S_EREQ, S_EWAIT
  } walk_state_t;

  localparam int EV_DESC = 0;
  localparam int EV_LAST = 1;
  localparam int EV_ERR  = 2;

  function automatic logic ptr_aligned(logic [31:0] p);
    return p[3:0] == 4'd0;
  endfunction

  function automatic logic rect_ok(rect_t r, int unsigned w, int unsigned h);
    return (r.x1 >= r.x0) && (r.y1 >= r.y0) &&
           (32'(r.x1) < w) && (32'(r.y1) < h);
  endfunction

  function automatic logic [31:0] word_addr(logic [31:0] base, logic [1:0] idx);
    return base + {28'd0, idx, 2'b00};
  endfunction

endpackage

// File: rtl/refill_rect_iter.sv
module refill_rect_iter
  import refill_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  rect_t      rect,
  input  logic       step,
  output logic [7:0] x,
  output logic [7:0] y,
  output logic       last
);
  logic [7:0] x0_q, x1_q, y1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x <= '0; y <= '0; x0_q <= '0; x1_q <= '0; y1_q <= '0;
    end else if (load) begin
      x <= rect.x0; y <= rect.y0;
      x0_q <= rect.x0; x1_q <= rect.x1; y1_q <= rect.y1;
    end else if (step) begin
      if (x == x1_q) begin
        x <= x0_q;
        y <= y + 8'd1;
      end else begin
        x <= x + 8'd1;
      end
    end
  end

  assign last = (x == x1_q) && (y == y1_q);

endmodule

// File: rtl/refill_walker.sv
module refill_walker
  import refill_pkg::*;
#(
  parameter int LUT_W = 256,
  parameter int LUT_H = 128,
  parameter int IDW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           cancel,
  input  logic [31:0]    start_ptr,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [31:0]    mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [31:0]    mem_rsp_data,
  output logic           lut_we,
  output logic [IDW-1:0] lut_id,
  output logic [7:0]     lut_x,
  output logic [7:0]     lut_y,
  output logic [31:0]    lut_data,
  output logic           ready,
  output logic           err,
  output logic [31:0]    cur_ptr,
  output logic           ev_desc,
  output logic           ev_last,
  output logic           ev_err
);
  walk_state_t    state;
  logic [1:0]     widx;
  logic [31:0]    ptr, next_q, dptr_q, eaddr;
  rect_t          rect_q;
  logic           ctrl_start;
  logic [IDW-1:0] ctrl_id;
  logic           discard;

  logic it_load, it_step, it_last;
  logic [7:0] it_x, it_y;

  logic accepted, in_wait, take_start, abort, desc_ok, ent_rsp, next_bad;

  assign accepted   = mem_req_valid && mem_req_ready;
  assign in_wait    = (state == S_DWAIT) || (state == S_EWAIT);
  assign take_start = (state == S_IDLE) && start && !discard;
  assign abort      = cancel && (state != S_IDLE);
  assign desc_ok    = rect_ok(rect_q, LUT_W, LUT_H) && ctrl_start && ptr_aligned(dptr_q);
  assign ent_rsp    = (state == S_EWAIT) && mem_rsp_valid && !cancel;
  assign next_bad   = ent_rsp && it_last && (next_q != 32'd0) && !ptr_aligned(next_q);

  assign ev_desc = (state == S_CHECK) && !cancel;
  assign ev_last = ent_rsp && it_last && (next_q == 32'd0);
  assign ev_err  = (take_start && !ptr_aligned(start_ptr)) || (ev_desc && !desc_ok) || next_bad;

  assign it_load = ev_desc && desc_ok;
  assign it_step = ent_rsp && !it_last;

  assign ready         = (state == S_IDLE) && !discard;
  assign mem_req_valid = (state == S_DREQ) || (state == S_EREQ);
  assign mem_req_addr  = (state == S_EREQ) ? eaddr : word_addr(ptr, widx);
  assign cur_ptr       = ptr;

  refill_rect_iter u_iter (
    .clk  (clk),
    .rst_n(rst_n),
    .load (it_load),
    .rect (rect_q),
    .step (it_step),
    .x    (it_x),
    .y    (it_y),
    .last (it_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; widx <= '0; ptr <= '0; next_q <= '0; dptr_q <= '0;
      eaddr <= '0; rect_q <= '0; ctrl_start <= 1'b0; ctrl_id <= '0;
      discard <= 1'b0; err <= 1'b0; lut_we <= 1'b0; lut_id <= '0;
      lut_x <= '0; lut_y <= '0; lut_data <= '0;
    end else begin
      lut_we <= 1'b0;
      if (ev_err) err <= 1'b1;
      else if (take_start) err <= 1'b0;

      if (abort) begin
        state   <= S_IDLE;
        discard <= (in_wait && !mem_rsp_valid) || accepted;
      end else begin
        case (state)
          S_IDLE: begin
            if (discard && mem_rsp_valid) discard <= 1'b0;
            if (take_start && ptr_aligned(start_ptr)) begin
              ptr   <= start_ptr;
              widx  <= 2'd0;
              state <= S_DREQ;
            end
          end
          S_DREQ: if (accepted) state <= S_DWAIT;
          S_DWAIT: if (mem_rsp_valid) begin
            case (widx)
              2'd0: next_q <= mem_rsp_data;
              2'd1: rect_q <= rect_t'(mem_rsp_data);
              2'd2: begin
                ctrl_start <= mem_rsp_data[0];
                ctrl_id    <= mem_rsp_data[4 +: IDW];
              end
              default: dptr_q <= mem_rsp_data;
            endcase
            if (widx == 2'd3) state <= S_CHECK;
            else begin
              widx  <= widx + 2'd1;
              state <= S_DREQ;
            end
          end
          S_CHECK: begin
            if (desc_ok) begin
              eaddr <= dptr_q;
              state <= S_EREQ;
            end else begin
              state <= S_IDLE;
            end
          end
          S_EREQ: if (accepted) state <= S_EWAIT;
          S_EWAIT: if (mem_rsp_valid) begin
            lut_we   <= 1'b1;
            lut_x    <= it_x;
            lut_y    <= it_y;
            lut_id   <= ctrl_id;
            lut_data <= mem_rsp_data;
            if (it_last) begin
              if (next_q == 32'd0 || !ptr_aligned(next_q)) begin
                state <= S_IDLE;
              end else begin
                ptr   <= next_q;
                widx  <= 2'd0;
                state <= S_DREQ;
              end
            end else begin
              eaddr <= eaddr + 32'd4;
              state <= S_EREQ;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r5_ready_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req_valid);

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !cancel |=> mem_req_valid && $stable(mem_req_addr));

  a_r9_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !lut_we);

  a_r3_write_in_rect: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we |-> (lut_x >= rect_q.x0) && (lut_x <= rect_q.x1) &&
               (lut_y >= rect_q.y0) && (lut_y <= rect_q.y1));

  a_r7_err_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> ready && err);

endmodule

// File: rtl/refill_regs.sv
module refill_regs
  import refill_pkg::*;
#(
  parameter int NUM_LUT = 1,
  parameter int LUT_W   = 256,
  parameter int LUT_H   = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        start,
  output logic        cancel,
  output logic [31:0] start_ptr,
  input  logic        ready,
  input  logic        err,
  input  logic [31:0] cur_ptr,
  input  logic        ev_desc,
  input  logic        ev_last,
  input  logic        ev_err,
  output logic        irq
);
  localparam logic [31:0] INFO_WORD = {3'd0, 5'd1, 3'd0, 5'(NUM_LUT), 16'd0};
  localparam logic [31:0] GEOM_WORD = {4'd0, 4'(LUT_H / 32), 4'd0, 4'(LUT_W / 32), 16'd0};

  logic [7:0] ev_stat, ev_en, ev_set, ev_clr;

  assign start     = cfg_we && (cfg_addr == 3'd0) && (cfg_wdata != 32'd0);
  assign cancel    = cfg_we && (cfg_addr == 3'd0) && (cfg_wdata == 32'd0);
  assign start_ptr = cfg_wdata;

  always_comb begin
    ev_set = '0;
    ev_set[EV_DESC] = ev_desc;
    ev_set[EV_LAST] = ev_last;
    ev_set[EV_ERR]  = ev_err;
    ev_clr = (cfg_we && cfg_addr == 3'd2) ? cfg_wdata[7:0] : 8'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_stat <= '0;
      ev_en   <= '0;
    end else begin
      ev_stat <= (ev_stat & ~ev_clr) | ev_set;
      if (cfg_we && cfg_addr == 3'd3) ev_en <= cfg_wdata[7:0];
    end
  end

  assign irq = |(ev_stat & ev_en);

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = cur_ptr;
      3'd1:    cfg_rdata = {30'd0, err, ready};
      3'd2:    cfg_rdata = {24'd0, ev_stat};
      3'd3:    cfg_rdata = {24'd0, ev_en};
      3'd4:    cfg_rdata = INFO_WORD;
      3'd5:    cfg_rdata = GEOM_WORD;
      default: cfg_rdata = 32'd0;
    endcase
  end

  a_r6_w1c_last: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 3'd2 && cfg_wdata[EV_LAST] && !ev_last |=> !ev_stat[EV_LAST]);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> ev_stat[EV_LAST]);

endmodule

// File: rtl/lut_refill_engine.sv
module lut_refill_engine
  import refill_pkg::*;
#(
  parameter int LUT_W   = 256,
  parameter int LUT_H   = 128,
  parameter int NUM_LUT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        irq,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        lut_we,
  output logic [3:0]  lut_id,
  output logic [7:0]  lut_x,
  output logic [7:0]  lut_y,
  output logic [31:0] lut_data
);
  logic start, cancel, ready, err, ev_desc, ev_last, ev_err;
  logic [31:0] start_ptr, cur_ptr;

  refill_regs #(.NUM_LUT(NUM_LUT), .LUT_W(LUT_W), .LUT_H(LUT_H)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start(start),
    .cancel(cancel), .start_ptr(start_ptr), .ready(ready), .err(err),
    .cur_ptr(cur_ptr), .ev_desc(ev_desc), .ev_last(ev_last),
    .ev_err(ev_err), .irq(irq)
  );

  refill_walker #(.LUT_W(LUT_W), .LUT_H(LUT_H), .IDW(4)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
    .start_ptr(start_ptr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .lut_we(lut_we), .lut_id(lut_id), .lut_x(lut_x), .lut_y(lut_y),
    .lut_data(lut_data), .ready(ready), .err(err), .cur_ptr(cur_ptr),
    .ev_desc(ev_desc), .ev_last(ev_last), .ev_err(ev_err)
  );

endmodule

// File: tb/lut_refill_engine_test.sv
`timescale 1ns/1ps
module lut_refill_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic irq, mem_req_valid, lut_we;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, lut_data;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'd0;
  logic [3:0] lut_id;
  logic [7:0] lut_x, lut_y;

  always #2 clk = ~clk;

  lut_refill_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .lut_we(lut_we), .lut_id(lut_id),
    .lut_x(lut_x), .lut_y(lut_y), .lut_data(lut_data)
  );

  int total = 0, bad = 0, cyc = 0, req_cnt = 0;
  bit finished = 0;
  logic [31:0] mem [0:1023];
  logic p1_v = 1'b0;
  logic [31:0] p1_d = 32'd0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    p1_v <= mem_req_valid && mem_req_ready;
    p1_d <= mem[mem_req_addr[11:2]];
    mem_rsp_valid <= p1_v;
    mem_rsp_data <= p1_d;
  end

  always @(negedge clk) mem_req_ready <= ($urandom % 10) < 7;

  int obs_n = 0;
  logic [7:0] obs_x [0:255];
  logic [7:0] obs_y [0:255];
  logic [3:0] obs_id [0:255];
  logic [31:0] obs_d [0:255];
  always @(negedge clk) begin
    if (mem_req_valid && mem_req_ready) req_cnt <= req_cnt + 1;
    if (lut_we && obs_n < 256) begin
      obs_x[obs_n] <= lut_x; obs_y[obs_n] <= lut_y;
      obs_id[obs_n] <= lut_id; obs_d[obs_n] <= lut_data;
      obs_n <= obs_n + 1;
    end
  end

  int exp_n = 0;
  logic [7:0] exp_x [0:255];
  logic [7:0] exp_y [0:255];
  logic [3:0] exp_id [0:255];
  logic [31:0] exp_d [0:255];
  bit exp_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic put_desc(input int a, input logic [31:0] nxt, input int x0, input int y0,
                          input int x1, input int y1, input logic [31:0] ctl,
                          input logic [31:0] dp, input int nfill);
    mem[a/4]     = nxt;
    mem[a/4 + 1] = {y1[7:0], x1[7:0], y0[7:0], x0[7:0]};
    mem[a/4 + 2] = ctl;
    mem[a/4 + 3] = dp;
    for (int k = 0; k < nfill; k++) mem[(dp/4 + k) % 1024] = $urandom;
  endtask

  // Expected writes from R3, R4, R7, R8: walk the chain in the memory model.
  task automatic build_expect(input logic [31:0] head);
    logic [31:0] p, nx, c, ctl, dp;
    int k, x0, y0, x1, y1;
    exp_n = 0; exp_err = 0; p = head;
    for (int guard = 0; guard < 32; guard++) begin
      if (p[3:0] != 0) begin exp_err = 1; break; end
      nx = mem[p/4]; c = mem[p/4 + 1]; ctl = mem[p/4 + 2]; dp = mem[p/4 + 3];
      x0 = c[7:0]; y0 = c[15:8]; x1 = c[23:16]; y1 = c[31:24];
      if (x1 < x0 || y1 < y0 || x1 >= 256 || y1 >= 128 || !ctl[0] || dp[3:0] != 0) begin
        exp_err = 1; break;
      end
      k = 0;
      for (int yy = y0; yy <= y1; yy++)
        for (int xx = x0; xx <= x1; xx++) begin
          exp_x[exp_n] = 8'(xx); exp_y[exp_n] = 8'(yy);
          exp_id[exp_n] = ctl[7:4]; exp_d[exp_n] = mem[dp/4 + k];
          exp_n++; k++;
        end
      if (nx == 0) break;
      p = nx;
    end
  endtask

  task automatic start_chain(input logic [31:0] head);
    build_expect(head);
    obs_n = 0;
    wr(3'd0, head);
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    for (int t = 0; t < 5000; t++) begin
      rd(3'd1, s);
      if (s[0]) break;
    end
    @(negedge clk);
  endtask

  task automatic compare_writes(input int upto, input string req);
    for (int i = 0; i < upto; i++)
      chk(obs_x[i] == exp_x[i] && obs_y[i] == exp_y[i] && obs_id[i] == exp_id[i] &&
          obs_d[i] == exp_d[i], req, "slot write",
          {obs_id[i], obs_x[i], obs_y[i], obs_d[i][11:0]},
          {exp_id[i], exp_x[i], exp_y[i], exp_d[i][11:0]});
  endtask

  task automatic finish_chain(input bit clear_ev);
    logic [31:0] s, e;
    wait_ready();
    chk(obs_n == exp_n, "R3", "write count", obs_n, exp_n);
    compare_writes((obs_n < exp_n) ? obs_n : exp_n, "R3");
    rd(3'd1, s);
    chk(s[1] == exp_err, exp_err ? "R7" : "R8", "error bit", s[1], exp_err);
    rd(3'd2, e);
    chk(e[1] == !exp_err && e[2] == exp_err, "R6", "event last/err", e, {29'd0, exp_err, !exp_err, 1'b0});
    if (clear_ev) wr(3'd2, 32'hFF);
  endtask

  initial begin
    logic [31:0] v;
    int n, kind, c0, w, h, x0, y0, rq;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd1, v); chk(v == 32'h1, "R1", "status", v, 32'h1);
    rd(3'd2, v); chk(v == 32'h0, "R1", "events", v, 32'h0);
    chk(!irq && !mem_req_valid && !lut_we, "R1", "outputs idle", {irq, mem_req_valid, lut_we}, 0);

    // R2 identification
    rd(3'd4, v); chk(v == 32'h01010000, "R2", "info", v, 32'h01010000);
    rd(3'd5, v); chk(v == 32'h04080000, "R2", "geometry", v, 32'h04080000);

    // R3/R4 single directed descriptor, then R10/R6 event masking
    put_desc(32'h10, 0, 5, 7, 7, 8, 32'h31, 32'h100, 6);
    start_chain(32'h10);
    finish_chain(1'b0);
    rd(3'd2, v); chk(v == 32'h3, "R10", "desc+last events", v, 32'h3);
    wr(3'd3, 32'h7E);
    chk(irq == 1'b1, "R10", "irq from last", irq, 1);
    wr(3'd2, 32'h2);
    rd(3'd2, v); chk(v == 32'h1, "R6", "w1c last", v, 32'h1);
    chk(irq == 1'b0, "R10", "advisory masked", irq, 0);
    wr(3'd3, 32'h01);
    chk(irq == 1'b1, "R10", "advisory enabled", irq, 1);
    wr(3'd2, 32'hFF); wr(3'd3, 32'h0);

    // R7 misaligned head: no memory read
    rq = req_cnt;
    start_chain(32'h108);
    finish_chain(1'b1);
    chk(req_cnt == rq, "R7", "no read on bad head", req_cnt, rq);

    // R7 misaligned next pointer after a valid descriptor
    put_desc(32'h90, 32'h48, 3, 3, 4, 3, 32'h21, 32'h500, 2);
    start_chain(32'h90);
    finish_chain(1'b1);

    // R5 busy: ready low and a second start ignored
    put_desc(32'h60, 0, 20, 10, 23, 12, 32'h51, 32'h300, 12);
    put_desc(32'h70, 0, 40, 40, 41, 40, 32'h61, 32'h340, 2);
    start_chain(32'h60);
    repeat (3) @(negedge clk);
    rd(3'd1, v); chk(v[0] == 1'b0, "R5", "ready low while busy", v, 0);
    wr(3'd0, 32'h70);
    finish_chain(1'b1);

    // R9 cancel mid-rectangle with responses in flight
    put_desc(32'h80, 0, 10, 5, 17, 8, 32'h71, 32'h400, 32);
    start_chain(32'h80);
    for (int t = 0; t < 2000 && obs_n < 5; t++) @(negedge clk);
    wr(3'd0, 32'h0);
    c0 = obs_n;
    repeat (40) @(negedge clk);
    chk(obs_n == c0, "R9", "no write after cancel", obs_n, c0);
    chk(obs_n < exp_n, "R9", "chain cut short", obs_n, exp_n);
    compare_writes(obs_n, "R9");
    rd(3'd1, v); chk(v[0] == 1'b1, "R9", "ready after cancel", v, 1);
    wr(3'd2, 32'hFF);
    put_desc(32'h10, 0, 100, 20, 102, 21, 32'h11, 32'h100, 6);
    start_chain(32'h10);
    finish_chain(1'b1);

    // Random chains, faults injected on the last descriptor (R3, R4, R7, R8)
    for (int it = 0; it < 40; it++) begin
      n = 1 + $urandom % 3;
      for (int i = 0; i < n; i++) begin
        w = 1 + $urandom % 4; h = 1 + $urandom % 3;
        x0 = 1 + $urandom % 250; y0 = $urandom % 120;
        put_desc(16 * (i + 1), (i == n - 1) ? 32'd0 : 32'(16 * (i + 2)),
                 x0, y0, x0 + w - 1, y0 + h - 1,
                 {24'd0, 4'($urandom), 4'd1}, 32'(32'h100 + 32'h40 * i), w * h);
        if (i == n - 1 && ($urandom % 5) == 0) begin
          kind = $urandom % 4;
          case (kind)
            0: mem[4 * (i + 1) + 3] = 32'h104 + 32'h40 * i;
            1: mem[4 * (i + 1) + 1] = {8'(y0), 8'(x0 - 1), 8'(y0), 8'(x0)};
            2: mem[4 * (i + 1) + 2] = 32'h30;
            default: mem[4 * (i + 1) + 1] = {8'd130, 8'(x0), 8'd130, 8'(x0)};
          endcase
        end
      end
      start_chain(32'h10);
      finish_chain(1'b1);
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule